// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Temperature Sensor Slave

This block is the serial target side of a digital temperature sensor. It watches the two-wire clock and data lines, which it oversamples on the system clock. It answers one 7-bit bus address, and it serves four registers through a pointer that it keeps between transactions. The four registers are a read-only temperature word, a configuration byte, and an upper and a lower threshold word. A master selects a register by writing a pointer byte. It then either writes data into that register in the same transaction, or issues a repeated start and reads from it. A plain read with no pointer byte uses whichever register was selected last.

Temperature samples come in on a valid-qualified sample port. Each accepted sample is cut to the resolution selected in the configuration byte. A sample that arrives while a bus read is in progress is dropped, so a word read over the bus never mixes two samples. Whenever a read of any register finishes, the block gives a single-cycle strobe that the thermal alarm logic uses to clear itself. The configuration byte and both thresholds are also brought out in parallel for that alarm logic.

Top module: `tsense_link`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 1001 followed by the three address pins, msb first; the lowest bit is the direction, 1 meaning read. Any other address gets no acknowledge, and the block then stays silent until the next start.
- R2: After a write address, the next byte is a pointer. Bits [1:0] select the register: 00 temperature, 01 configuration, 10 lower threshold, 11 upper threshold. A pointer byte with any of bits [7:2] set is not acknowledged, the stored pointer keeps its old value, and the transaction is abandoned.
- R3: The pointer resets to 00 and keeps its value across transactions. A read issued without a pointer byte uses the stored pointer.
- R4: After reset, the configuration byte is 0x00, the upper threshold is 0x5000, the lower threshold is 0x4B00 and the temperature word is 0x0000. The data line is released.
- R5: The temperature register and both threshold registers return two bytes, most significant first. The configuration register returns a single byte, and the data line stays released after that byte's acknowledge clock.
- R6: Data bytes that follow the pointer in the same transaction are written to the selected register and acknowledged: one byte for configuration, two bytes (high byte first) for a threshold. A data byte beyond the register's length is not acknowledged. Bytes aimed at the temperature register are acknowledged and discarded.
- R7: The four least significant bits of both threshold registers are always zero. Written values in those bits are dropped.
- R8: A sample presented with its valid bit while no read is in progress replaces the temperature word. Only its top 9 + N bits are kept, where N is configuration bits [6:5], and the lower bits become zero.
- R9: A sample that arrives while a read is in progress does not change the temperature word, either during that read or afterwards.
- R10: Every completed register read produces exactly one read-strobe pulse, one system-clock cycle long. The pulse comes in the master-acknowledge clock of the last byte.
- R11: In a two-byte read, the block sends the second byte whatever the master answered to the first. If that byte's leading bit is 0, the line stays low through an attempted stop. After nine more clocks the line is released and a stop returns the block to idle.
- R12: A start or stop condition at any point aborts the transfer in progress and releases the data line. A threshold write cut short after its first data byte leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Data-line pull-down enable; 1 drives the line low |
| addr_pins_i | input | 3 | Low three bits of the bus address |
| smp_valid_i | input | 1 | Qualifies a new temperature sample |
| smp_i | input | 16 | Temperature sample, two's complement, 1/256 degree per LSB |
| rd_strobe_o | output | 1 | One-cycle pulse when a register read completes |
| cfg_o | output | 8 | Current configuration byte |
| thr_hi_o | output | 16 | Current upper threshold word |
| thr_lo_o | output | 16 | Current lower threshold word |

## Verification
The bench sweeps all 128 address bytes and all 256 pointer bytes. A decoder that ignored the pin bits or the upper pointer bits would acknowledge bytes it must refuse, and the stored pointer would then point at the wrong register. Samples are pushed under every resolution setting, and one sample is pushed in the middle of a word read. A wrong truncation mask, or an update during the read, would show up as a torn or mixed word when the register is read back. A read is cut short after one byte while the next bit to send is zero. A design that gave up the line on a master NACK would let the stop through too early, and a design that never recovers would fail the transaction that follows. Writes that are too long, writes to the read-only register and an aborted threshold write are also read back, to show that nothing else changed.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [1:0] SEL_TEMP = 2'b00;
    localparam logic [1:0] SEL_CFG  = 2'b01;
    localparam logic [1:0] SEL_LO   = 2'b10;
    localparam logic [1:0] SEL_HI   = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXDONE,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_TXNEXT
    } link_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } link_ph_e;

    typedef struct packed {
        link_st_e            st;
        link_ph_e            ph;
        logic [3:0]          cnt;
        logic [BYTE_W-1:0]   sh;
        logic [1:0]          ptr;
        logic                rw;
        logic                ack;
        logic [1:0]          bidx;
        logic [BYTE_W-1:0]   hold;
        logic                oe;
        logic                rd_busy;
        logic                rd_stb;
        logic                wr_stb;
        logic [WORD_W-1:0]   wr_word;
    } link_state_t;

endpackage

// File: rtl/tsl_bus_cond.sv
module tsl_bus_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } cond_t;

    cond_t q, d;
    logic  scl_s, sda_s;

    assign scl_s = q.scl_sh[STAGES-1];
    assign sda_s = q.sda_sh[STAGES-1];

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_s_o    = sda_s;
    assign scl_rise_o = scl_s & ~q.scl_p;
    assign scl_fall_o = ~scl_s & q.scl_p;
    assign start_o    = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_o     = scl_s & q.scl_p & ~q.sda_p & sda_s;

    // R12: at most one bus event is reported per cycle
    a_r12_event_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o}));

endmodule

// File: rtl/tsl_regs.sv
module tsl_regs #(
    parameter int          DW      = 16,
    parameter int          ZB      = 4,
    parameter int          MIN_RES = 9,
    parameter int          RES_LSB = 5,
    parameter logic [15:0] HI_RST  = 16'h5000,
    parameter logic [15:0] LO_RST  = 16'h4B00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ptr_i,
    input  logic          wr_stb_i,
    input  logic [DW-1:0] wr_word_i,
    input  logic          rd_busy_i,
    input  logic          smp_valid_i,
    input  logic [DW-1:0] smp_i,
    output logic [DW-1:0] rd_word_o,
    output logic [7:0]    cfg_o,
    output logic [DW-1:0] thr_hi_o,
    output logic [DW-1:0] thr_lo_o
);
    import tsl_pkg::*;

    localparam logic [DW-1:0] THR_KEEP = {{(DW-ZB){1'b1}}, {ZB{1'b0}}};

    typedef struct packed {
        logic [7:0]    cfg;
        logic [DW-1:0] thi;
        logic [DW-1:0] tlo;
        logic [DW-1:0] temp;
    } regs_t;

    regs_t         q, d;
    logic [DW-1:0] res_keep;
    int            drop_bits;

    always_comb begin
        drop_bits = DW - MIN_RES - int'(q.cfg[RES_LSB +: 2]);
        res_keep  = {DW{1'b1}} << drop_bits;
        d = q;
        if (wr_stb_i) begin
            unique case (ptr_i)
                SEL_CFG: d.cfg = wr_word_i[7:0];
                SEL_HI:  d.thi = wr_word_i & THR_KEEP;
                SEL_LO:  d.tlo = wr_word_i & THR_KEEP;
                default: d.temp = q.temp;
            endcase
        end
        if (smp_valid_i && !rd_busy_i) d.temp = smp_i & res_keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg  <= '0;
            q.thi  <= HI_RST;
            q.tlo  <= LO_RST;
            q.temp <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (ptr_i)
            SEL_TEMP: rd_word_o = q.temp;
            SEL_CFG:  rd_word_o = {{(DW-8){1'b0}}, q.cfg};
            SEL_LO:   rd_word_o = q.tlo;
            default:  rd_word_o = q.thi;
        endcase
    end

    assign cfg_o    = q.cfg;
    assign thr_hi_o = q.thi;
    assign thr_lo_o = q.tlo;

    // R9: the readable temperature does not move while a read is in flight
    a_r9_temp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy_i |=> $stable(q.temp));

endmodule

// File: rtl/tsl_link_fsm.sv
module tsl_link_fsm #(
    parameter logic [3:0] ADDR_HI = 4'b1001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sda_s_i,
    input  logic        scl_rise_i,
    input  logic        scl_fall_i,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic [2:0]  addr_pins_i,
    input  logic [15:0] rd_word_i,
    output logic        sda_oe_o,
    output logic [1:0]  ptr_o,
    output logic        wr_stb_o,
    output logic [15:0] wr_word_o,
    output logic        rd_busy_o,
    output logic        rd_stb_o
);
    import tsl_pkg::*;

    localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
    localparam logic [3:0] ALL_BITS = 4'(BYTE_W);

    link_state_t       q, d;
    logic [BYTE_W-1:0] rx_b;
    logic [BYTE_W-1:0] first_b;
    logic              two_byte;
    logic [1:0]        wlen;

    always_comb begin
        two_byte = (q.ptr != SEL_CFG);
        wlen     = two_byte ? 2'd2 : 2'd1;
        first_b  = two_byte ? rd_word_i[15:8] : rd_word_i[7:0];
        rx_b     = {q.sh[BYTE_W-2:0], sda_s_i};

        d        = q;
        d.rd_stb = 1'b0;
        d.wr_stb = 1'b0;

        if (stop_i) begin
            d.st      = ST_IDLE;
            d.oe      = 1'b0;
            d.rd_busy = 1'b0;
        end else if (start_i) begin
            d.st      = ST_RX;
            d.ph      = PH_ADDR;
            d.cnt     = '0;
            d.oe      = 1'b0;
            d.rd_busy = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise_i) begin
                        d.sh  = rx_b;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == LAST_BIT) begin
                            d.st = ST_RXDONE;
                            unique case (q.ph)
                                PH_ADDR: begin
                                    d.ack = (rx_b[7:1] == {ADDR_HI, addr_pins_i});
                                    d.rw  = rx_b[0];
                                end
                                PH_PTR: begin
                                    d.ack = (rx_b[7:2] == '0);
                                    if (rx_b[7:2] == '0) d.ptr = rx_b[1:0];
                                end
                                default: begin
                                    d.ack = (q.bidx < wlen);
                                    if (q.bidx < wlen) begin
                                        d.bidx = q.bidx + 2'd1;
                                        if (q.ptr == SEL_CFG) begin
                                            d.wr_stb  = 1'b1;
                                            d.wr_word = {8'h00, rx_b};
                                        end else if (q.ptr != SEL_TEMP) begin
                                            if (q.bidx == 2'd0) begin
                                                d.hold = rx_b;
                                            end else begin
                                                d.wr_stb  = 1'b1;
                                                d.wr_word = {q.hold, rx_b};
                                            end
                                        end
                                    end
                                end
                            endcase
                        end
                    end
                end
                ST_RXDONE: begin
                    if (scl_fall_i) begin
                        d.st = q.ack ? ST_ACK : ST_IDLE;
                        d.oe = q.ack;
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_RX;
                        unique case (q.ph)
                            PH_ADDR: begin
                                if (q.rw) begin
                                    d.st      = ST_TX;
                                    d.sh      = first_b;
                                    d.oe      = ~first_b[7];
                                    d.bidx    = 2'd0;
                                    d.rd_busy = 1'b1;
                                end else begin
                                    d.ph = PH_PTR;
                                end
                            end
                            PH_PTR: begin
                                d.ph   = PH_DATA;
                                d.bidx = 2'd0;
                            end
                            default: d.ph = PH_DATA;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise_i) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i) begin
                        if (q.cnt == ALL_BITS) begin
                            d.st = ST_MACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        if (two_byte && q.bidx == 2'd0) begin
                            d.st = ST_TXNEXT;
                        end else begin
                            d.st      = ST_IDLE;
                            d.rd_stb  = 1'b1;
                            d.rd_busy = 1'b0;
                        end
                    end
                end
                ST_TXNEXT: begin
                    if (scl_fall_i) begin
                        d.st   = ST_TX;
                        d.sh   = rd_word_i[7:0];
                        d.oe   = ~rd_word_i[7];
                        d.cnt  = '0;
                        d.bidx = 2'd1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.ph <= PH_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign ptr_o     = q.ptr;
    assign wr_stb_o  = q.wr_stb;
    assign wr_word_o = q.wr_word;
    assign rd_busy_o = q.rd_busy;
    assign rd_stb_o  = q.rd_stb;

    // R10: read strobe lasts a single cycle
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_stb |=> !q.rd_stb);

    // R12: a stop condition leaves the data line released
    a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_oe_o);

    // R6: register writes are only issued from the data phase
    a_r6_write_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_stb |-> ($past(q.ph) == PH_DATA));

    // R3: the pointer only moves while a pointer byte is being received
    a_r3_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.st == ST_RX && q.ph == PH_PTR) |=> $stable(q.ptr));

endmodule

// File: rtl/tsense_link.sv
module tsense_link #(
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  ADDR_HI     = 4'b1001,
    parameter int          THR_ZERO    = 4,
    parameter logic [15:0] HI_RST      = 16'h5000,
    parameter logic [15:0] LO_RST      = 16'h4B00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [2:0]  addr_pins_i,
    input  logic        smp_valid_i,
    input  logic [15:0] smp_i,
    output logic        rd_strobe_o,
    output logic [7:0]  cfg_o,
    output logic [15:0] thr_hi_o,
    output logic [15:0] thr_lo_o
);

    logic        sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic [1:0]  ptr;
    logic        wr_stb, rd_busy;
    logic [15:0] wr_word, rd_word;

    tsl_bus_cond #(.STAGES(SYNC_STAGES)) cond_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    tsl_link_fsm #(.ADDR_HI(ADDR_HI)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s_i     (sda_s),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_c),
        .stop_i      (stop_c),
        .addr_pins_i (addr_pins_i),
        .rd_word_i   (rd_word),
        .sda_oe_o    (sda_oe_o),
        .ptr_o       (ptr),
        .wr_stb_o    (wr_stb),
        .wr_word_o   (wr_word),
        .rd_busy_o   (rd_busy),
        .rd_stb_o    (rd_strobe_o)
    );

    tsl_regs #(
        .DW     (16),
        .ZB     (THR_ZERO),
        .HI_RST (HI_RST),
        .LO_RST (LO_RST)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_i       (ptr),
        .wr_stb_i    (wr_stb),
        .wr_word_i   (wr_word),
        .rd_busy_i   (rd_busy),
        .smp_valid_i (smp_valid_i),
        .smp_i       (smp_i),
        .rd_word_o   (rd_word),
        .cfg_o       (cfg_o),
        .thr_hi_o    (thr_hi_o),
        .thr_lo_o    (thr_lo_o)
    );

endmodule

// File: tb/tsense_link_tb_top.sv
`timescale 1ns/1ps
module tsense_link_tb_top;

    localparam int T = 8;
    localparam int H = T / 2;
    localparam logic [7:0] AW = 8'h9A;
    localparam logic [7:0] AR = 8'h9B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic        smp_valid = 1'b0;
    logic [15:0] smp = '0;
    logic        rd_strobe;
    logic [7:0]  cfg;
    logic [15:0] thr_hi, thr_lo;

    int n_chk = 0;
    int n_fail = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    tsense_link dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .addr_pins_i (3'b101),
        .smp_valid_i (smp_valid),
        .smp_i       (smp),
        .rd_strobe_o (rd_strobe),
        .cfg_o       (cfg),
        .thr_hi_o    (thr_hi),
        .thr_lo_o    (thr_lo)
    );

    always @(posedge clk) if (rd_strobe) stb_cnt <= stb_cnt + 1;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        tick(H); sda_m = 1'b1; tick(H); scl = 1'b1; tick(T);
        sda_m = 1'b0; tick(T); scl = 1'b0;
    endtask

    task automatic bus_stop;
        tick(H); sda_m = 1'b0; tick(H); scl = 1'b1; tick(T);
        sda_m = 1'b1; tick(T);
    endtask

    task automatic wb(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(H); sda_m = b[i]; tick(H); scl = 1'b1; tick(T); scl = 1'b0;
        end
        tick(H); sda_m = 1'b1; tick(H); scl = 1'b1; tick(H);
        ack = ~sda_line; tick(H); scl = 1'b0;
    endtask

    task automatic rb(input logic mack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(T); scl = 1'b1; tick(H); v[i] = sda_line; tick(H); scl = 1'b0;
        end
        tick(H); sda_m = mack; tick(H); scl = 1'b1; tick(T); scl = 1'b0;
        tick(H); sda_m = 1'b1;
    endtask

    task automatic wr_reg(input logic [7:0] p, input int n, input logic [15:0] w, input string req);
        logic a;
        bus_start;
        wb(AW, a); chk("R1 write address ack", 16'(a), 16'h1);
        wb(p, a);  chk("R2 pointer ack", 16'(a), 16'h1);
        if (n == 2) begin
            wb(w[15:8], a); chk(req, 16'(a), 16'h1);
        end
        wb(w[7:0], a); chk(req, 16'(a), 16'h1);
        bus_stop;
    endtask

    task automatic rd_reg(input logic setp, input logic [7:0] p, input int n, output logic [15:0] w);
        logic a;
        logic [7:0] hi, lo;
        bus_start;
        if (setp) begin
            wb(AW, a); wb(p, a);
            bus_start;
        end
        wb(AR, a); chk("R1 read address ack", 16'(a), 16'h1);
        hi = 8'h00;
        if (n == 2) rb(1'b0, hi);
        rb(1'b1, lo);
        bus_stop;
        w = {hi, lo};
    endtask

    task automatic push(input logic [15:0] v);
        smp = v; smp_valid = 1'b1; tick(1); smp_valid = 1'b0; tick(1);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
    end

    initial begin
        logic a;
        logic [7:0] v;
        logic [15:0] w;
        logic [15:0] m;
        int s0;
        tick(10); rst_n = 1'b1; tick(5);

        // R4: reset state
        chk("R4 sda released", 16'(sda_oe), 16'h0);
        chk("R4 cfg", 16'(cfg), 16'h0000);
        chk("R4 upper thr", thr_hi, 16'h5000);
        chk("R4 lower thr", thr_lo, 16'h4B00);
        s0 = stb_cnt;
        rd_reg(1'b0, 8'h00, 2, w);
        chk("R3 R4 default pointer reads temperature", w, 16'h0000);
        chk("R10 one strobe per read", 16'(stb_cnt - s0), 16'h1);

        // R1: every address byte
        for (int ad = 0; ad < 128; ad++) begin
            bus_start; wb({7'(ad), 1'b0}, a); bus_stop;
            chk("R1 address match", 16'(a), (ad == 7'h4D) ? 16'h1 : 16'h0);
        end

        // R2: every pointer byte
        for (int p = 0; p < 256; p++) begin
            bus_start; wb(AW, a); wb(8'(p), a); bus_stop;
            chk("R2 pointer accept", 16'(a), (p < 4) ? 16'h1 : 16'h0);
        end
        rd_reg(1'b0, 8'h00, 2, w);
        chk("R3 R5 stored pointer is last accepted (upper)", w, 16'h5000);

        // R6: config write, overlong write
        bus_start; wb(AW, a); wb(8'h01, a); wb(8'h20, a);
        chk("R6 cfg data ack", 16'(a), 16'h1);
        wb(8'h55, a);
        chk("R6 extra byte nack", 16'(a), 16'h0);
        bus_stop;
        chk("R6 cfg written once", 16'(cfg), 16'h0020);
        wr_reg(8'h01, 1, 16'h0060, "R6 cfg ack");
        chk("R6 cfg value", 16'(cfg), 16'h0060);

        // R7: threshold low nibble
        wr_reg(8'h03, 2, 16'h1234, "R6 upper ack");
        chk("R7 upper low nibble zero", thr_hi, 16'h1230);
        rd_reg(1'b1, 8'h03, 2, w);
        chk("R5 R7 upper readback", w, 16'h1230);
        wr_reg(8'h02, 2, 16'hABCF, "R6 lower ack");
        chk("R7 lower low nibble zero", thr_lo, 16'hABC0);
        wr_reg(8'h00, 2, 16'hFFFF, "R6 temperature write ack");
        rd_reg(1'b0, 8'h00, 2, w);
        chk("R6 temperature read-only", w, 16'h0000);

        // R12: aborted threshold write
        bus_start; wb(AW, a); wb(8'h03, a); wb(8'h77, a); bus_stop;
        chk("R12 aborted write no effect", thr_hi, 16'h1230);

        // R5 R10: single-byte config read
        s0 = stb_cnt;
        bus_start; wb(AW, a); wb(8'h01, a); bus_start; wb(AR, a);
        rb(1'b1, v);
        tick(T);
        chk("R5 config one byte released", 16'(sda_line), 16'h1);
        bus_stop;
        chk("R5 config value", 16'(v), 16'h0060);
        chk("R10 strobe on config read", 16'(stb_cnt - s0), 16'h1);

        // R8: resolution sweep
        for (int r = 0; r < 4; r++) begin
            m = 16'hFFFF << (7 - r);
            wr_reg(8'h01, 1, 16'(r << 5), "R6 cfg ack");
            push(16'hFFFF);
            rd_reg(1'b1, 8'h00, 2, w);
            chk("R8 resolution mask ones", w, m);
            push(16'hA5A5);
            rd_reg(1'b0, 8'h00, 2, w);
            chk("R8 resolution mask pattern", w, 16'hA5A5 & m);
        end

        // R9: sample during read
        push(16'h1230);
        bus_start; wb(AR, a);
        rb(1'b0, v);
        chk("R9 first byte", 16'(v), 16'h0012);
        push(16'h7FF0);
        rb(1'b1, v);
        chk("R9 second byte from old sample", 16'(v), 16'h0030);
        bus_stop;
        rd_reg(1'b0, 8'h00, 2, w);
        chk("R9 masked sample dropped", w, 16'h1230);
        push(16'h0450);
        rd_reg(1'b0, 8'h00, 2, w);
        chk("R8 idle sample accepted", w, 16'h0450);

        // R11: truncated read locks line until nine clocks pass
        bus_start; wb(AR, a);
        rb(1'b1, v);
        chk("R11 first byte", 16'(v), 16'h0004);
        tick(H); sda_m = 1'b0; tick(H); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
        chk("R11 line held low through stop attempt", 16'(sda_line), 16'h0);
        scl = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(T); scl = 1'b1; tick(T); scl = 1'b0;
        end
        tick(T);
        chk("R11 line released after nine clocks", 16'(sda_line), 16'h1);
        bus_stop;
        rd_reg(1'b0, 8'h00, 2, w);
        chk("R11 normal after recovery", w, 16'h0450);

        summary;
    end

endmodule